// File: doc/BRIEF.md
# Decorated Store AND Bridge

This block sits on an AHB-Lite path between one bus master and one peripheral slave port. Most transfers cross it untouched: address, control and write data go straight to the slave, and the slave's ready, response and read data come straight back, with no register in between. A write to an alias address whose top bits carry an AND command is handled differently. It becomes an atomic read-modify-write on the real peripheral location. The bridge reads the location, combines the read value with the write data by a bitwise AND over the addressed byte lanes, and writes the result back. It holds the master stalled for the whole sequence.

The alias is found in the top six address bits. The physical address is recovered by masking away the command field and the unused middle bits. The access size comes from the write transfer itself. The master is expected to replicate byte and halfword data across lanes already, as AHB masters normally do. Slave wait states and error responses reach the master with their timing kept intact.

Top module: `dand_bridge`

## Requirements
- R1: A transfer is a decorated AND when HTRANS is NONSEQ or SEQ, HWRITE is 1 and address bits [31:26] are 6'b010001 (bits [31:29]=010, bits [28:26]=001). Bits [25:20] are ignored.
- R2: A decorated AND is presented to the slave first as a read, in the same cycle as the master's address phase. Its address is the master address ANDed with 32'hE00F_FFFF, and its HSIZE is the master's.
- R3: After a read that completes OKAY, the bridge issues a write to the same stripped address and size, with no idle cycle between. The write data is the read data ANDed with the master write data on the selected byte lanes.
- R4: Lanes are selected by HSIZE (0 byte, 1 halfword, 2 word) and by address bits [1:0]. Byte n covers data bits [8n+7:8n]. A halfword at bit1=1 covers bytes 3..2. Unselected lanes of the write-back carry the read data unchanged.
- R5: With a zero-wait slave, the master's data phase for a decorated AND lasts exactly 2 cycles. ready_o is low until the write-back completes, and the final cycle is OKAY.
- R6: Each slave wait state adds exactly one stalled master cycle. With w waits on each slave phase, the master data phase lasts 2w+2 cycles.
- R7: An ERROR on the read step means no write is issued and the location is left unchanged. The master receives the two-cycle ERROR response.
- R8: An ERROR on the write-back step is returned to the master as the two-cycle ERROR response, ending the sequence.
- R9: Non-decorated reads and writes, and reads of the decorated alias range, reach the slave with their address unchanged and no added cycles. Write data is not modified.
- R10: Two decorated ANDs issued back to back on the master are both carried out correctly.
- R11: After reset, with the master idle, ready_o is 1, resp_o is OKAY and the slave sees HTRANS IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| haddr_i | input | 32 | Master address |
| htrans_i | input | 2 | Master transfer type |
| hwrite_i | input | 1 | Master write strobe |
| hsize_i | input | 3 | Master transfer size |
| hwdata_i | input | 32 | Master write data |
| hrdata_o | output | 32 | Read data returned to the master |
| hready_o | output | 1 | Transfer done, to the master |
| hresp_o | output | 1 | Error response, to the master |
| s_haddr_o | output | 32 | Slave address |
| s_htrans_o | output | 2 | Slave transfer type |
| s_hwrite_o | output | 1 | Slave write strobe |
| s_hsize_o | output | 3 | Slave transfer size |
| s_hwdata_o | output | 32 | Slave write data |
| s_hrdata_i | input | 32 | Slave read data |
| s_hready_i | input | 1 | Slave ready |
| s_hresp_i | input | 1 | Slave error response |

## Verification
Decorated ANDs are run against a word, each byte lane, both halfword halves and an alias with the ignored bits set. Any mistake in the lane select or in the address mask then shows up as a wrong memory word, which a word-only test would not catch. Each case runs with its own slave wait count, so the stall length tells correct wait propagation apart from a fixed delay. Read-side and write-side errors are injected separately, so an aborted write-back can be told apart from one that was issued anyway. Plain writes, a plain byte write and an alias-range read confirm that nothing outside decorated writes is changed, and a back-to-back pair exercises the pipelined hand-over.

// File: rtl/dand_pkg.sv
package dand_pkg;
  typedef enum logic [1:0] {ST_PASS, ST_RD, ST_WR} st_e;
  localparam logic [1:0] HTRANS_IDLE = 2'b00;
  localparam logic [1:0] HTRANS_NSEQ = 2'b10;
endpackage

// File: rtl/dand_decode.sv
module dand_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] KEY_MASK = 32'hFC00_0000,
  parameter logic [ADDR_W-1:0] KEY_VAL  = 32'h4400_0000,
  parameter logic [ADDR_W-1:0] STRIP    = 32'hE00F_FFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] phys_o
);
  assign hit_o  = (addr_i & KEY_MASK) == KEY_VAL;
  assign phys_o = addr_i & STRIP;
endmodule

// File: rtl/dand_lane_merge.sv
module dand_lane_merge #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]                rd_i,
  input  logic [DATA_W-1:0]                wd_i,
  input  logic [2:0]                       size_i,
  input  logic [$clog2(DATA_W/8)-1:0]      lo_i,
  output logic [DATA_W-1:0]                data_o
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned LIDX  = $clog2(LANES);

  logic [2:0] sz;
  assign sz = (size_i > 3'(LIDX)) ? 3'(LIDX) : size_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic sel;
    // lane belongs to the addressed container of 2**sz bytes
    assign sel = (LIDX'(g) >> sz) == (lo_i >> sz);
    assign data_o[8*g +: 8] = sel ? (rd_i[8*g +: 8] & wd_i[8*g +: 8]) : rd_i[8*g +: 8];
  end
endmodule

// File: rtl/dand_bridge.sv
module dand_bridge #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic [DATA_W-1:0] hwdata_i,
  output logic [DATA_W-1:0] hrdata_o,
  output logic              hready_o,
  output logic              hresp_o,
  output logic [ADDR_W-1:0] s_haddr_o,
  output logic [1:0]        s_htrans_o,
  output logic              s_hwrite_o,
  output logic [2:0]        s_hsize_o,
  output logic [DATA_W-1:0] s_hwdata_o,
  input  logic [DATA_W-1:0] s_hrdata_i,
  input  logic              s_hready_i,
  input  logic              s_hresp_i
);
  import dand_pkg::*;
  localparam int unsigned LIDX = $clog2(DATA_W / 8);

  st_e               state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        size_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] merged;
  logic [ADDR_W-1:0] phys;
  logic              key_hit, dec_hit, own_addr;

  dand_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (haddr_i),
    .hit_o  (key_hit),
    .phys_o (phys)
  );

  dand_lane_merge #(.DATA_W(DATA_W)) u_merge (
    .rd_i   (s_hrdata_i),
    .wd_i   (hwdata_i),
    .size_i (size_q),
    .lo_i   (addr_q[LIDX-1:0]),
    .data_o (merged)
  );

  assign dec_hit  = key_hit && hwrite_i && htrans_i[1];
  // during the read data phase the bridge owns the address channel unless aborting
  assign own_addr = (state_q == ST_RD) && !s_hresp_i;

  always_comb begin
    if (own_addr) begin
      s_haddr_o  = addr_q;
      s_htrans_o = HTRANS_NSEQ;
      s_hwrite_o = 1'b1;
      s_hsize_o  = size_q;
    end else begin
      s_haddr_o  = dec_hit ? phys : haddr_i;
      s_htrans_o = htrans_i;
      s_hwrite_o = dec_hit ? 1'b0 : hwrite_i;
      s_hsize_o  = hsize_i;
    end
  end

  assign s_hwdata_o = (state_q == ST_WR) ? wdata_q : hwdata_i;
  assign hready_o   = s_hready_i && !own_addr;
  assign hresp_o    = s_hresp_i;
  assign hrdata_o   = s_hrdata_i;

  always_comb begin
    state_d = state_q;
    if (own_addr && s_hready_i) state_d = ST_WR;
    else if (hready_o)          state_d = dec_hit ? ST_RD : ST_PASS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PASS;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (hready_o && dec_hit) begin
        addr_q <= phys;
        size_q <= hsize_i;
      end
      if (own_addr && s_hready_i) wdata_q <= merged;
    end
  end
endmodule

// File: rtl/dand_bridge_chk.sv
module dand_bridge_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] haddr_i,
  input logic [1:0]        htrans_i,
  input logic              hwrite_i,
  input logic              hready_o,
  input logic              hresp_o,
  input logic [ADDR_W-1:0] s_haddr_o,
  input logic [1:0]        s_htrans_o,
  input logic              s_hwrite_o,
  input logic              s_hready_i,
  input logic              s_hresp_i,
  input dand_pkg::st_e     state_q
);
  import dand_pkg::*;
  logic dec_acc;
  assign dec_acc = hready_o && htrans_i[1] && hwrite_i && (haddr_i[31:26] == 6'b010001);

  p_read_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_acc |-> (!s_hwrite_o && s_htrans_o == htrans_i && s_haddr_o == (haddr_i & 32'hE00F_FFFF)));

  p_hold_master_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_acc |=> !hready_o);

  p_wb_same_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD && s_hready_i && !s_hresp_i) |->
      (s_hwrite_o && s_htrans_o == 2'b10 && $stable(s_haddr_o)));

  p_no_wb_on_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD && s_hresp_i) |=> state_q != ST_WR);

  p_pass_resp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RD) |-> (hready_o == s_hready_i && hresp_o == s_hresp_i));
endmodule

bind dand_bridge dand_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .haddr_i    (haddr_i),
  .htrans_i   (htrans_i),
  .hwrite_i   (hwrite_i),
  .hready_o   (hready_o),
  .hresp_o    (hresp_o),
  .s_haddr_o  (s_haddr_o),
  .s_htrans_o (s_htrans_o),
  .s_hwrite_o (s_hwrite_o),
  .s_hready_i (s_hready_i),
  .s_hresp_i  (s_hresp_i),
  .state_q    (state_q)
);

// File: tb/dand_bridge_bench.sv
module dand_bridge_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] haddr_i = '0;
  logic [1:0]  htrans_i = 2'b00;
  logic        hwrite_i = 1'b0;
  logic [2:0]  hsize_i = 3'd0;
  logic [31:0] hwdata_i = '0;
  logic [31:0] hrdata_o;
  logic        hready_o, hresp_o;
  logic [31:0] s_haddr_o;
  logic [1:0]  s_htrans_o;
  logic        s_hwrite_o;
  logic [2:0]  s_hsize_o;
  logic [31:0] s_hwdata_o;
  logic [31:0] s_hrdata_i;
  logic        s_hready_i, s_hresp_i;

  always #4 clk_i = ~clk_i;

  dand_bridge u_dand_bridge (.*);

  // slave model
  logic [31:0] mem [16];
  logic        dp_valid = 1'b0, dp_write = 1'b0, dp_err = 1'b0, err_stage = 1'b0;
  logic [31:0] dp_addr = '0;
  logic [2:0]  dp_size = '0;
  logic [3:0]  wait_cnt = '0;
  logic [3:0]  cfg_wait = '0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic        err_on_write = 1'b0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
  int          wr_cnt = 0;
  logic        pl_en = 1'b0;
  logic [3:0]  pl_idx = '0;
  logic [31:0] pl_data = '0;

  assign s_hready_i = !dp_valid || (wait_cnt == 0 && (!dp_err || err_stage));
  assign s_hresp_i  = dp_valid && dp_err && wait_cnt == 0;
  assign s_hrdata_i = mem[dp_addr[5:2]];

  function automatic logic lane_on(input logic [2:0] sz, input logic [1:0] lo, input int i);
    return ((i >> sz) == (int'(lo) >> sz));
  endfunction

  always @(posedge clk_i) begin
    if (pl_en) mem[pl_idx] <= pl_data;
    if (dp_valid && s_hready_i && dp_write && !dp_err) begin
      for (int i = 0; i < 4; i++)
        if (lane_on(dp_size, dp_addr[1:0], i)) mem[dp_addr[5:2]][8*i +: 8] <= s_hwdata_o[8*i +: 8];
      wr_cnt <= wr_cnt + 1;
    end
    if (s_hready_i && s_htrans_o[1]) begin
      dp_valid  <= 1'b1;
      dp_write  <= s_hwrite_o;
      dp_addr   <= s_haddr_o;
      dp_size   <= s_hsize_o;
      wait_cnt  <= cfg_wait;
      err_stage <= 1'b0;
      dp_err    <= (s_haddr_o == err_addr) && (s_hwrite_o == err_on_write);
      if (s_hwrite_o) last_wr_addr <= s_haddr_o; else last_rd_addr <= s_haddr_o;
    end else if (s_hready_i) begin
      dp_valid <= 1'b0;
    end else if (wait_cnt != 0) begin
      wait_cnt <= wait_cnt - 1;
    end else if (dp_err) begin
      err_stage <= 1'b1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk_i);
    pl_en = 1'b1; pl_idx = idx; pl_data = d;
    @(negedge clk_i);
    pl_en = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] a, input logic wr, input logic [2:0] sz, input logic [31:0] wd,
                      output logic [31:0] rd, output logic resp, output int cyc);
    @(negedge clk_i);
    haddr_i = a; htrans_i = 2'b10; hwrite_i = wr; hsize_i = sz;
    while (!hready_o) @(negedge clk_i);
    @(negedge clk_i);
    htrans_i = 2'b00; hwdata_i = wd;
    cyc = 1;
    while (!hready_o) begin
      cyc++;
      @(negedge clk_i);
    end
    rd = hrdata_o; resp = hresp_o;
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  size;
    logic [31:0] wdata;
    logic [31:0] init;
    logic [31:0] expv;
    logic [3:0]  waits;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h4400_0000, 3'd2, 32'h0F0F_F0F0, 32'hFFFF_0000, 32'h0F0F_0000, 4'd0},
    '{32'h4400_0006, 3'd0, 32'h5A5A_5A5A, 32'h12F3_4567, 32'h1252_4567, 4'd0},
    '{32'h44F0_000A, 3'd1, 32'h00FF_00FF, 32'hABCD_1234, 32'h00CD_1234, 4'd1},
    '{32'h4400_000C, 3'd0, 32'h0F0F_0F0F, 32'h8888_88F8, 32'h8888_8808, 4'd2},
    '{32'h4400_0013, 3'd0, 32'h3C3C_3C3C, 32'hFF00_00FF, 32'h3C00_00FF, 4'd0},
    '{32'h4400_0014, 3'd1, 32'hF00F_F00F, 32'h1234_5678, 32'h1234_5008, 4'd3}
  };

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        resp;
    int          cyc, wc;
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11", "hready_o in reset", {31'b0, hready_o}, 32'd1);
    chk("R11", "s_htrans_o in reset", {30'b0, s_htrans_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11", "hready_o after reset", {31'b0, hready_o}, 32'd1);
    chk("R11", "hresp_o after reset", {31'b0, hresp_o}, 32'd0);

    // R1 R2 R3 R4 R5 R6 table walk
    foreach (VECS[k]) begin
      preload(VECS[k].addr[5:2], VECS[k].init);
      cfg_wait = VECS[k].waits;
      xfer(VECS[k].addr, 1'b1, VECS[k].size, VECS[k].wdata, rd, resp, cyc);
      @(negedge clk_i);
      chk("R3_R4", $sformatf("vec%0d memory", k), mem[VECS[k].addr[5:2]], VECS[k].expv);
      chk("R2", $sformatf("vec%0d read addr", k), last_rd_addr, VECS[k].addr & 32'hE00F_FFFF);
      chk("R3", $sformatf("vec%0d write addr", k), last_wr_addr, VECS[k].addr & 32'hE00F_FFFF);
      chk("R5_R6", $sformatf("vec%0d stall cycles", k), cyc, 2 * VECS[k].waits + 2);
      chk("R5", $sformatf("vec%0d resp", k), {31'b0, resp}, 32'd0);
    end

    // R9 plain word write with waits, then plain byte write (no AND)
    cfg_wait = 4'd2;
    xfer(32'h4000_0020, 1'b1, 3'd2, 32'hDEAD_BEEF, rd, resp, cyc);
    @(negedge clk_i);
    chk("R9", "plain write cycles", cyc, 32'd3);
    chk("R9", "plain write mem", mem[8], 32'hDEAD_BEEF);
    chk("R9", "plain write addr", last_wr_addr, 32'h4000_0020);
    cfg_wait = 4'd0;
    xfer(32'h4000_0021, 1'b1, 3'd0, 32'h7777_7777, rd, resp, cyc);
    @(negedge clk_i);
    chk("R9", "plain byte write mem", mem[8], 32'hDEAD_77EF);
    chk("R9", "plain byte cycles", cyc, 32'd1);

    // R9 read in alias range forwarded unmodified
    xfer(32'h4400_0004, 1'b0, 3'd2, 32'h0, rd, resp, cyc);
    chk("R9", "alias read data", rd, 32'h1252_4567);
    chk("R9", "alias read addr", last_rd_addr, 32'h4400_0004);
    chk("R9", "alias read cycles", cyc, 32'd1);

    // R7 error on read step
    preload(4'd9, 32'hFFFF_FFFF);
    err_addr = 32'h4000_0024; err_on_write = 1'b0;
    wc = wr_cnt;
    xfer(32'h4400_0024, 1'b1, 3'd2, 32'h0, rd, resp, cyc);
    @(negedge clk_i);
    chk("R7", "read err resp", {31'b0, resp}, 32'd1);
    chk("R7", "read err cycles", cyc, 32'd2);
    chk("R7", "read err mem", mem[9], 32'hFFFF_FFFF);
    chk("R7", "read err no write", wr_cnt, wc);

    // R8 error on write-back step
    preload(4'd10, 32'h0000_FFFF);
    err_addr = 32'h4000_0028; err_on_write = 1'b1;
    xfer(32'h4400_0028, 1'b1, 3'd2, 32'h0, rd, resp, cyc);
    @(negedge clk_i);
    chk("R8", "write err resp", {31'b0, resp}, 32'd1);
    chk("R8", "write err cycles", cyc, 32'd3);
    chk("R8", "write err mem", mem[10], 32'h0000_FFFF);
    err_addr = 32'hFFFF_FFFF;

    // R10 back-to-back decorated writes
    preload(4'd11, 32'hF0F0_F0F0);
    preload(4'd12, 32'hFFFF_FFFF);
    @(negedge clk_i);
    haddr_i = 32'h4400_002C; htrans_i = 2'b10; hwrite_i = 1'b1; hsize_i = 3'd2;
    @(negedge clk_i);
    haddr_i = 32'h4400_0030; hwdata_i = 32'h3C3C_3C3C;
    while (!hready_o) @(negedge clk_i);
    @(negedge clk_i);
    htrans_i = 2'b00; hwdata_i = 32'h0000_FFFF;
    while (!hready_o) @(negedge clk_i);
    resp = hresp_o;
    @(negedge clk_i);
    chk("R10", "first mem", mem[11], 32'h3030_3030);
    chk("R10", "second mem", mem[12], 32'h0000_FFFF);
    chk("R10", "resp", {31'b0, resp}, 32'd0);

    // R9 R1: decorated-range read with ignored bits does not modify memory
    xfer(32'h44F0_002C, 1'b0, 3'd2, 32'h0, rd, resp, cyc);
    @(negedge clk_i);
    chk("R1", "read not decorated", rd, 32'h3030_3030);
    chk("R1", "read kept addr", last_rd_addr, 32'h44F0_002C);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule